// File: doc/BRIEF.md
# Two-Level Interrupt Aggregation Controller

This block collects interrupt events from two Ethernet PHY ports, twelve general-purpose I/O lines and five host MAC sources, and merges them into one active-high interrupt request pin. PHY and GPIO events are first captured in second-level sticky status registers, each with its own per-bit mask. Each masked group is reduced to one summary bit in a top-level status register. MAC events are captured directly in that top-level register.

The top-level status is gated by a top-level enable register. A single output-enable bit in a configuration register then gates the pin. Software services an interrupt in three steps: it reads the top-level status, follows the summary bit down to the leaf register, and writes one to the flagged bits to clear them. The summary bit and the pin then fall by themselves.

The register port is a plain synchronous write strobe with a 3-bit word address. Read data is combinational from the current register state.

Top module: `irq_agg_top`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Each PHY source register (address 3 for port A, address 5 for port B) holds seven sticky flags. Bit 0 is energy detected, bit 1 auto-negotiation done, bit 2 link-partner acknowledge, bit 3 page received, bit 4 parallel-detect fault, bit 5 remote fault and bit 6 link lost. A one-cycle pulse on the matching event input sets a flag. Writing one to a flag clears it, and writing zero leaves it unchanged.
- R3: If an event sets a leaf status bit in the same cycle that a write-one-to-clear targets it, the bit ends up set.
- R4: Top-level status bit 26 is the OR of port A source AND port A mask (mask at address 4). Bit 27 is the same for port B (mask at address 6). Both bits are read-only, so writing ones to them has no effect.
- R5: The GPIO register (address 7) holds per-pin sticky status in bits [11:0] and writable per-pin enables in bits [27:16]. Status bits clear on a write of one. Top-level status bit 12 is the OR of status AND enable.
- R6: MAC events go straight into top-level status bits [4:0], in this order: TX stopped, RX stopped, drop counter halfway, TX complete and RX DMA. They are sticky and clear on a write of one at address 0.
- R7: `irq` is registered. One clock edge after the register state changes, it equals the output-enable bit ANDed with the OR of (top-level status AND top-level enable).
- R8: In the configuration register (address 2), bit 8 is the IRQ output enable. All other bits read zero.
- R9: The top-level enable register (address 1) implements bits 27, 26, 12 and [4:0], each enabling the same-numbered status bit. Writes to other bits are dropped and read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_a_evt | input | 7 | Port A PHY event pulses |
| phy_b_evt | input | 7 | Port B PHY event pulses |
| gpio_evt | input | 12 | GPIO interrupt event pulses |
| mac_evt | input | 5 | Host MAC event pulses |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| irq | output | 1 | Interrupt request, active high |

## Verification
Leaf and top-level status become visible on `reg_rdata` after the clock edge that samples an event or a write. That is the first result due. The summary bits follow combinationally at the same edge. `irq` needs one more edge, because it is registered from the status, enable and output-enable state.

The bench applies inputs after the falling edge and compares read data and `irq` just after that. It uses a reference model that updates at each rising edge and keeps last edge's `irq` prediction separate from the new register state. Every result is therefore checked in exactly the cycle it is due.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int DW        = 32;
  localparam int AW        = 3;
  localparam int PHY_EVTS  = 7;
  localparam int GPIO_PINS = 12;
  localparam int MAC_EVTS  = 5;

  // word addresses
  localparam logic [AW-1:0] A_TOP_STS = 3'd0;
  localparam logic [AW-1:0] A_TOP_EN  = 3'd1;
  localparam logic [AW-1:0] A_CFG     = 3'd2;
  localparam logic [AW-1:0] A_PA_SRC  = 3'd3;
  localparam logic [AW-1:0] A_PA_MSK  = 3'd4;
  localparam logic [AW-1:0] A_PB_SRC  = 3'd5;
  localparam logic [AW-1:0] A_PB_MSK  = 3'd6;
  localparam logic [AW-1:0] A_GPIO    = 3'd7;

  // bit positions that software decodes
  localparam int B_PHY_A   = 26;
  localparam int B_PHY_B   = 27;
  localparam int B_GPIO    = 12;
  localparam int B_OE      = 8;
  localparam int MAC_LSB   = 0;
  localparam int GPIO_ENLS = 16;
endpackage

// File: rtl/irq_leaf.sv
// Sticky status bank with per-bit mask and a masked summary output.
module irq_leaf #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         clr_we,
  input  logic [W-1:0] clr_bits,
  input  logic         msk_we,
  input  logic [W-1:0] msk_bits,
  output logic [W-1:0] sts,
  output logic [W-1:0] msk,
  output logic         summary
);
  logic [W-1:0] sts_q, sts_d;
  logic [W-1:0] msk_q, msk_d;
  logic [W-1:0] clr_eff;

  always_comb begin
    clr_eff = clr_we ? clr_bits : '0;
    sts_d   = (sts_q & ~clr_eff) | evt;  // event dominates the clear
    msk_d   = msk_we ? msk_bits : msk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      msk_q <= '0;
    end else begin
      sts_q <= sts_d;
      msk_q <= msk_d;
    end
  end

  assign sts     = sts_q;
  assign msk     = msk_q;
  assign summary = |(sts_q & msk_q);
endmodule

// File: rtl/irq_top_ctl.sv
// Top-level status/enable, output enable and registered request pin.
module irq_top_ctl
  import irq_agg_pkg::*;
#(
  parameter int DWID = DW,
  parameter int NMAC = MAC_EVTS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NMAC-1:0] mac_evt,
  input  logic [1:0]      phy_sum,
  input  logic            gpio_sum,
  input  logic            sts_we,
  input  logic            en_we,
  input  logic            cfg_we,
  input  logic [DWID-1:0] wdata,
  output logic [DWID-1:0] top_sts,
  output logic [DWID-1:0] top_en,
  output logic            irq_oe,
  output logic            irq
);
  localparam logic [DWID-1:0] ONE     = DWID'(1);
  localparam logic [DWID-1:0] EN_IMPL = (ONE << B_PHY_A) | (ONE << B_PHY_B) |
                                        (ONE << B_GPIO) |
                                        (DWID'((1 << NMAC) - 1) << MAC_LSB);

  logic [NMAC-1:0] mac_q, mac_d;
  logic [DWID-1:0] en_q, en_d;
  logic            oe_q, oe_d;
  logic            irq_q, irq_d;
  logic [NMAC-1:0] mac_clr;

  always_comb begin
    top_sts                    = '0;
    top_sts[MAC_LSB +: NMAC]   = mac_q;
    top_sts[B_GPIO]            = gpio_sum;
    top_sts[B_PHY_A]           = phy_sum[0];
    top_sts[B_PHY_B]           = phy_sum[1];
  end

  always_comb begin
    mac_clr = sts_we ? wdata[MAC_LSB +: NMAC] : '0;
    mac_d   = (mac_q & ~mac_clr) | mac_evt;
    en_d    = en_we  ? (wdata & EN_IMPL) : en_q;
    oe_d    = cfg_we ? wdata[B_OE] : oe_q;
    irq_d   = oe_q & (|(top_sts & en_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mac_q <= '0;
      en_q  <= '0;
      oe_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      mac_q <= mac_d;
      en_q  <= en_d;
      oe_q  <= oe_d;
      irq_q <= irq_d;
    end
  end

  assign top_en = en_q;
  assign irq_oe = oe_q;
  assign irq    = irq_q;
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
#(
  parameter int NPHY  = PHY_EVTS,
  parameter int NGPIO = GPIO_PINS,
  parameter int NMAC  = MAC_EVTS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPHY-1:0]  phy_a_evt,
  input  logic [NPHY-1:0]  phy_b_evt,
  input  logic [NGPIO-1:0] gpio_evt,
  input  logic [NMAC-1:0]  mac_evt,
  input  logic             reg_we,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             irq
);
  localparam int NPORT = 2;

  // asynchronous assert, synchronous release
  logic [1:0] rst_q;
  logic       rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n_i = rst_q[1];

  logic [NPORT-1:0][NPHY-1:0] phy_evt, phy_src, phy_msk;
  logic [NPORT-1:0]           phy_sum;
  assign phy_evt[0] = phy_a_evt;
  assign phy_evt[1] = phy_b_evt;

  for (genvar gp = 0; gp < NPORT; gp++) begin : g_phy
    localparam logic [AW-1:0] SRC_A = AW'(A_PA_SRC + 2 * gp);
    localparam logic [AW-1:0] MSK_A = AW'(A_PA_MSK + 2 * gp);
    irq_leaf #(.W(NPHY)) u_leaf (
      .clk      (clk),
      .rst_n    (rst_n_i),
      .evt      (phy_evt[gp]),
      .clr_we   (reg_we && (reg_addr == SRC_A)),
      .clr_bits (reg_wdata[NPHY-1:0]),
      .msk_we   (reg_we && (reg_addr == MSK_A)),
      .msk_bits (reg_wdata[NPHY-1:0]),
      .sts      (phy_src[gp]),
      .msk      (phy_msk[gp]),
      .summary  (phy_sum[gp])
    );
  end

  logic [NGPIO-1:0] gpio_sts, gpio_en;
  logic             gpio_sum;
  logic             gpio_we;
  assign gpio_we = reg_we && (reg_addr == A_GPIO);

  irq_leaf #(.W(NGPIO)) u_gpio (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .evt      (gpio_evt),
    .clr_we   (gpio_we),
    .clr_bits (reg_wdata[NGPIO-1:0]),
    .msk_we   (gpio_we),
    .msk_bits (reg_wdata[GPIO_ENLS +: NGPIO]),
    .sts      (gpio_sts),
    .msk      (gpio_en),
    .summary  (gpio_sum)
  );

  logic [DW-1:0] top_sts, top_en;
  logic          irq_oe;

  irq_top_ctl #(.DWID(DW), .NMAC(NMAC)) u_top (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .mac_evt  (mac_evt),
    .phy_sum  (phy_sum),
    .gpio_sum (gpio_sum),
    .sts_we   (reg_we && (reg_addr == A_TOP_STS)),
    .en_we    (reg_we && (reg_addr == A_TOP_EN)),
    .cfg_we   (reg_we && (reg_addr == A_CFG)),
    .wdata    (reg_wdata),
    .top_sts  (top_sts),
    .top_en   (top_en),
    .irq_oe   (irq_oe),
    .irq      (irq)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_TOP_STS: reg_rdata = top_sts;
      A_TOP_EN:  reg_rdata = top_en;
      A_CFG:     reg_rdata[B_OE] = irq_oe;
      A_PA_SRC:  reg_rdata[NPHY-1:0] = phy_src[0];
      A_PA_MSK:  reg_rdata[NPHY-1:0] = phy_msk[0];
      A_PB_SRC:  reg_rdata[NPHY-1:0] = phy_src[1];
      A_PB_MSK:  reg_rdata[NPHY-1:0] = phy_msk[1];
      A_GPIO: begin
        reg_rdata[NGPIO-1:0]          = gpio_sts;
        reg_rdata[GPIO_ENLS +: NGPIO] = gpio_en;
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
  import irq_agg_pkg::*;
#(
  parameter int NPHY = PHY_EVTS
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq,
  input logic            irq_oe,
  input logic [DW-1:0]   top_sts,
  input logic [DW-1:0]   top_en,
  input logic [NPHY-1:0] pa_evt,
  input logic [NPHY-1:0] pa_src,
  input logic [NPHY-1:0] pa_msk,
  input logic            we,
  input logic [AW-1:0]   addr
);
  AST_IRQ_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(irq_oe)); // R7
  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(|(top_sts & top_en))); // R7
  AST_EVT_SETS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (|pa_evt) |=> ((pa_src & $past(pa_evt)) == $past(pa_evt))); // R3
  AST_SRC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((pa_evt == '0) && !(we && (addr == A_PA_SRC))) |=> $stable(pa_src)); // R2
  AST_SUMMARY_UP: assert property (@(posedge clk) disable iff (!rst_n)
    ((pa_src & pa_msk) != '0) |-> top_sts[B_PHY_A]); // R4
endmodule

bind irq_agg_top irq_agg_chk #(.NPHY(NPHY)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n_i),
  .irq     (irq),
  .irq_oe  (irq_oe),
  .top_sts (top_sts),
  .top_en  (top_en),
  .pa_evt  (phy_a_evt),
  .pa_src  (phy_src[0]),
  .pa_msk  (phy_msk[0]),
  .we      (reg_we),
  .addr    (reg_addr)
);

// File: tb/irq_agg_top_tb_top.sv
`timescale 1ns/1ps
module irq_agg_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  pa_evt = '0, pb_evt = '0;
  logic [11:0] g_evt = '0;
  logic [4:0]  m_evt = '0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  irq_agg_top dut_i (
    .clk(clk), .rst_n(rst_n), .phy_a_evt(pa_evt), .phy_b_evt(pb_evt),
    .gpio_evt(g_evt), .mac_evt(m_evt), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq)
  );

  // reference model
  logic [6:0]  m_src [2];
  logic [6:0]  m_msk [2];
  logic [11:0] m_gs, m_ge;
  logic [4:0]  m_mac;
  logic [31:0] m_en;
  logic        m_oe, m_irq;

  function automatic logic [31:0] f_top();
    logic [31:0] v = '0;
    v[4:0] = m_mac;
    v[12]  = |(m_gs & m_ge);
    v[26]  = |(m_src[0] & m_msk[0]);
    v[27]  = |(m_src[1] & m_msk[1]);
    return v;
  endfunction

  function automatic logic [31:0] f_read(input logic [2:0] a);
    case (a)
      3'd0: return f_top();
      3'd1: return m_en;
      3'd2: return {23'd0, m_oe, 8'd0};
      3'd3: return {25'd0, m_src[0]};
      3'd4: return {25'd0, m_msk[0]};
      3'd5: return {25'd0, m_src[1]};
      3'd6: return {25'd0, m_msk[1]};
      default: return {4'd0, m_ge, 4'd0, m_gs};
    endcase
  endfunction

  function automatic string f_tag(input logic [2:0] a);
    case (a)
      3'd0: return "R6";
      3'd1: return "R9";
      3'd2: return "R8";
      3'd3, 3'd5: return "R2";
      3'd4, 3'd6: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic m_reset();
    m_src[0] = '0; m_src[1] = '0; m_msk[0] = '0; m_msk[1] = '0;
    m_gs = '0; m_ge = '0; m_mac = '0; m_en = '0; m_oe = 0; m_irq = 0;
  endtask

  task automatic m_edge();
    logic nirq;
    logic [6:0] pe [2];
    nirq = m_oe & (|(f_top() & m_en));
    pe[0] = pa_evt; pe[1] = pb_evt;
    for (int p = 0; p < 2; p++) begin
      logic [6:0] clr = (we && addr == 3'(3 + 2 * p)) ? wdata[6:0] : 7'd0;
      m_src[p] = (m_src[p] & ~clr) | pe[p];
      if (we && addr == 3'(4 + 2 * p)) m_msk[p] = wdata[6:0];
    end
    if (we && addr == 3'd7) begin
      m_gs = (m_gs & ~wdata[11:0]) | g_evt;
      m_ge = wdata[27:16];
    end else m_gs = m_gs | g_evt;
    if (we && addr == 3'd0) m_mac = (m_mac & ~wdata[4:0]) | m_evt;
    else m_mac = m_mac | m_evt;
    if (we && addr == 3'd1) m_en = wdata & 32'h0C00_101F;
    if (we && addr == 3'd2) m_oe = wdata[8];
    m_irq = nirq;
  endtask

  // one cycle: drive after falling edge, check, step model at rising edge
  task automatic cyc(input logic [6:0] a, input logic [6:0] b, input logic [11:0] g,
                     input logic [4:0] m, input bit w, input logic [2:0] ad,
                     input logic [31:0] d);
    pa_evt = a; pb_evt = b; g_evt = g; m_evt = m; we = w; addr = ad; wdata = d;
    #1;
    chk(rdata == f_read(ad), f_tag(ad), rdata, f_read(ad));
    chk(irq == m_irq, "R7", {31'd0, irq}, {31'd0, m_irq});
    @(posedge clk);
    m_edge();
    @(negedge clk);
  endtask

  task automatic idle(); cyc('0, '0, '0, '0, 0, 3'd0, '0); endtask

  task automatic peek(input logic [2:0] ad, input logic [31:0] exp, input string tag);
    we = 0; addr = ad; #1;
    chk(rdata == exp, tag, rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B_3C4D));
    m_reset();
    repeat (3) @(negedge clk);
    // R1: reset values
    for (int a = 0; a < 8; a++) peek(3'(a), 32'd0, "R1");
    chk(irq == 1'b0, "R1", {31'd0, irq}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    idle();

    // R3: set wins over a same-cycle clear
    cyc(7'h01, '0, '0, '0, 0, 3'd0, '0);
    cyc(7'h01, '0, '0, '0, 1, 3'd3, 32'h7F);
    peek(3'd3, 32'h01, "R3");

    // R4: summary bit is read-only
    cyc('0, '0, '0, '0, 1, 3'd4, 32'h01);
    peek(3'd0, 32'h0400_0000, "R4");
    cyc('0, '0, '0, '0, 1, 3'd0, 32'hFFFF_FFFF);
    peek(3'd0, 32'h0400_0000, "R4");

    // R7: enable path, pin rises one edge after enable, falls one edge after clear
    cyc('0, '0, '0, '0, 1, 3'd1, 32'hFFFF_FFFF);
    peek(3'd1, 32'h0C00_101F, "R9");
    cyc('0, '0, '0, '0, 1, 3'd2, 32'hFFFF_FFFF);
    peek(3'd2, 32'h0000_0100, "R8");
    chk(irq == 1'b0, "R7", {31'd0, irq}, 32'd0);
    idle();
    chk(irq == 1'b1, "R7", {31'd0, irq}, 32'd1);
    cyc('0, '0, '0, '0, 1, 3'd3, 32'h01);
    chk(irq == 1'b1, "R7", {31'd0, irq}, 32'd1);
    idle();
    chk(irq == 1'b0, "R7", {31'd0, irq}, 32'd0);

    // R5 / R6 directed
    cyc('0, '0, 12'h800, 5'h10, 1, 3'd7, 32'h0800_0000);
    peek(3'd7, 32'h0800_0800, "R5");
    peek(3'd0, 32'h0000_1010, "R6");
    cyc('0, '0, '0, '0, 1, 3'd7, 32'h0800_0000);
    peek(3'd7, 32'h0800_0800, "R5");
    cyc('0, '0, '0, '0, 1, 3'd0, 32'h0000_0010);
    peek(3'd0, 32'h0000_1000, "R6");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] d = $urandom();
      if (($urandom() & 7) == 0) d = 32'hFFFF_FFFF;
      cyc(7'($urandom() & $urandom() & $urandom()),
          7'($urandom() & $urandom() & $urandom()),
          12'($urandom() & $urandom() & $urandom() & $urandom()),
          5'($urandom() & $urandom() & $urandom()),
          (($urandom() & 3) == 0), 3'($urandom()), d);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule